// File: doc/BRIEF.md
# SDRAM Bank and Power-Down State Tracker

This block watches the decoded command stream and clock-enable of a two-bank SDRAM and keeps a cycle-accurate copy of the device state. For each bank it records whether a row is open and which row that is. It also tracks whether the device is running normally, in power-down with every bank idle, or in power-down with a row open. It sits beside a memory controller or a bus monitor. Its outputs show the bank state and flag any illegal use of the device.

Every illegal use raises a one-cycle error pulse on the cycle after the offending command. The cases are: a read or write to a bank with no open row, an activate to a bank that already has a row open, and an activate issued before the precharge recovery time has passed. A separate level flag rises when power-down has lasted longer than the refresh interval. This interval is set as a parameter in clock cycles.

Commands are decoded only while clock-enable is high and the device is not in power-down. The whole device can be closed with one precharge-all command.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset, both banks read idle, both open rows read zero, the power mode reads 0 (running), and all error outputs are low.
- R2: An ACTIVE (cmd_i=2) with cke_i high in running mode, sent to an idle bank whose recovery time has elapsed, opens bank ba_i with row addr_i. bank_active_o and open_row_o show this one cycle later. open_row_o keeps the last opened row after the bank closes.
- R3: A PRECHARGE (cmd_i=5) with addr_i[10] low closes only the bank selected by ba_i.
- R4: A PRECHARGE with addr_i[10] high closes every bank whatever ba_i holds.
- R5: A READ (cmd_i=3) or WRITE (cmd_i=4) to an idle bank pulses err_no_row_o for one cycle. When sent to an open bank it raises no error and changes no state.
- R6: An ACTIVE to a bank issued fewer than T_RP cycles after that bank's PRECHARGE pulses err_trp_o and leaves the bank idle. At exactly T_RP cycles it succeeds.
- R7: An ACTIVE to a bank that is already open pulses err_reopen_o and leaves its row unchanged.
- R8: In running mode, cke_i low together with NOP (cmd_i=0) or INHIBIT (cmd_i=1) enters power-down. pwr_mode_o becomes 1 if all banks are idle and 2 if any row is open. The value 3 never appears.
- R9: In power-down, cke_i high together with NOP or INHIBIT returns pwr_mode_o to 0. Every other input pattern in power-down is ignored: it changes no bank state and raises no error.
- R10: err_pd_long_o is high while in power-down from PD_LIMIT cycles after the entry edge until exit. It is low otherwise.
- R11: In running mode, cke_i low with any command other than NOP or INHIBIT is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Sampled clock enable of the device |
| cmd_i | input | 3 | Decoded command: 0 NOP, 1 INHIBIT, 2 ACTIVE, 3 READ, 4 WRITE, 5 PRECHARGE, others ignored |
| ba_i | input | BA_W (1) | Bank address |
| addr_i | input | ADDR_W (12) | Row address for ACTIVE; bit 10 selects precharge-all |
| bank_active_o | output | NUM_BANKS (2) | One bit per bank, high when a row is open |
| open_row_o | output | NUM_BANKS*ROW_W (24) | Last opened row of each bank, bank 0 in the low bits |
| pwr_mode_o | output | 2 | 0 running, 1 power-down with all banks idle, 2 power-down with a row open |
| err_no_row_o | output | 1 | Pulse: read or write to an idle bank |
| err_trp_o | output | 1 | Pulse: activate before precharge recovery |
| err_reopen_o | output | 1 | Pulse: activate to an open bank |
| err_pd_long_o | output | 1 | Level: power-down has exceeded the refresh limit |

## Verification
The assertions assume that cmd_i and ba_i are always driven to known values, that only one command arrives per cycle, and that the power mode alone decides whether a command is decoded. The exact recovery counters are not visible at the ports, so the properties only check the timing of error pulses and bank freezing that follow from port values. The bench sets every input to a defined value after each falling edge. Its random stimulus keeps cke_i high most of the time, so that decoded commands and power-down entries and exits are frequent. A directed long power-down drives the refresh-limit flag.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_INH = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_PRE = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_RUN    = 2'd0,
    PWR_PRE_PD = 2'd1,
    PWR_ACT_PD = 2'd2
  } pwr_mode_e;

  localparam int unsigned PRE_ALL_BIT = 10;
endpackage

// File: rtl/sdram_trk_bank.sv
module sdram_trk_bank #(
  parameter int unsigned ROW_W = 12,
  parameter int unsigned T_RP  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             acc_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             active_o,
  output logic [ROW_W-1:0] row_o,
  output logic             err_norow_o,
  output logic             err_trp_o,
  output logic             err_reopen_o
);
  localparam int unsigned TRP_W = (T_RP < 2) ? 1 : $clog2(T_RP + 1);
  localparam logic [TRP_W-1:0] TRP_LOAD = TRP_W'(T_RP - 1);

  logic [TRP_W-1:0] trp_q;
  logic             recovered;

  assign recovered = (trp_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o     <= 1'b0;
      row_o        <= '0;
      trp_q        <= '0;
      err_norow_o  <= 1'b0;
      err_trp_o    <= 1'b0;
      err_reopen_o <= 1'b0;
    end else begin
      err_norow_o  <= acc_i & ~active_o;
      err_trp_o    <= act_i & ~active_o & ~recovered;
      err_reopen_o <= act_i & active_o;
      if (pre_i) begin
        active_o <= 1'b0;
        trp_q    <= TRP_LOAD;
      end else begin
        if (!recovered) trp_q <= trp_q - 1'b1;
        if (act_i && !active_o && recovered) begin
          active_o <= 1'b1;
          row_o    <= row_i;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_trk_pd.sv
module sdram_trk_pd
  import sdram_trk_pkg::*;
#(
  parameter int unsigned PD_LIMIT = 3_200_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cke_i,
  input  logic       idle_cmd_i,
  input  logic       any_open_i,
  output logic [1:0] mode_o,
  output logic       in_pd_o,
  output logic       long_o
);
  localparam int unsigned CNT_W = $clog2(PD_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PD_LIMIT);

  pwr_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q;

  assign in_pd_o = (mode_q != PWR_RUN);
  assign mode_o  = mode_q;
  assign long_o  = in_pd_o && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PWR_RUN;
      cnt_q  <= '0;
    end else if (!in_pd_o) begin
      cnt_q <= '0;
      if (!cke_i && idle_cmd_i) mode_q <= any_open_i ? PWR_ACT_PD : PWR_PRE_PD;
    end else if (cke_i && idle_cmd_i) begin
      mode_q <= PWR_RUN;
      cnt_q  <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned PD_LIMIT  = 3_200_000,
  localparam int unsigned BA_W     = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cke_i,
  input  logic [2:0]                 cmd_i,
  input  logic [BA_W-1:0]            ba_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic [NUM_BANKS-1:0]       bank_active_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
  output logic [1:0]                 pwr_mode_o,
  output logic                       err_no_row_o,
  output logic                       err_trp_o,
  output logic                       err_reopen_o,
  output logic                       err_pd_long_o
);
  logic                 in_pd, valid, idle_cmd, pre_all;
  logic [NUM_BANKS-1:0] norow_v, trp_v, reopen_v;

  assign valid    = cke_i & ~in_pd;
  assign idle_cmd = (cmd_i == CMD_NOP) || (cmd_i == CMD_INH);
  assign pre_all  = addr_i[PRE_ALL_BIT];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (ba_i == BA_W'(b));
    sdram_trk_bank #(.ROW_W(ROW_W), .T_RP(T_RP)) bank_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .act_i        (valid && hit && cmd_i == CMD_ACT),
      .pre_i        (valid && cmd_i == CMD_PRE && (hit || pre_all)),
      .acc_i        (valid && hit && (cmd_i == CMD_RD || cmd_i == CMD_WR)),
      .row_i        (addr_i[ROW_W-1:0]),
      .active_o     (bank_active_o[b]),
      .row_o        (open_row_o[b*ROW_W +: ROW_W]),
      .err_norow_o  (norow_v[b]),
      .err_trp_o    (trp_v[b]),
      .err_reopen_o (reopen_v[b])
    );
  end

  sdram_trk_pd #(.PD_LIMIT(PD_LIMIT)) pd_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cke_i      (cke_i),
    .idle_cmd_i (idle_cmd),
    .any_open_i (|bank_active_o),
    .mode_o     (pwr_mode_o),
    .in_pd_o    (in_pd),
    .long_o     (err_pd_long_o)
  );

  assign err_no_row_o = |norow_v;
  assign err_trp_o    = |trp_v;
  assign err_reopen_o = |reopen_v;
endmodule

// File: rtl/sdram_trk_chk.sv
module sdram_trk_chk
  import sdram_trk_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned BA_W      = 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       cke_i,
  input logic [2:0]                 cmd_i,
  input logic [BA_W-1:0]            ba_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [NUM_BANKS-1:0]       bank_active_o,
  input logic [NUM_BANKS*ROW_W-1:0] open_row_o,
  input logic [1:0]                 pwr_mode_o,
  input logic                       err_no_row_o,
  input logic                       err_trp_o,
  input logic                       err_reopen_o,
  input logic                       err_pd_long_o
);
  logic run_cmd, idle_cmd;
  assign run_cmd  = cke_i && (pwr_mode_o == PWR_RUN);
  assign idle_cmd = (cmd_i == CMD_NOP) || (cmd_i == CMD_INH);

  assert_mode_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_mode_o != 2'd3);

  assert_pd_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_mode_o != PWR_RUN) |=> ($stable(bank_active_o) && !err_trp_o && !err_reopen_o));

  assert_pre_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_cmd && cmd_i == CMD_PRE && addr_i[PRE_ALL_BIT]) |=> (bank_active_o == '0));

  assert_reopen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_cmd && cmd_i == CMD_ACT && bank_active_o[ba_i]) |=> (err_reopen_o && $stable(open_row_o)));

  assert_no_row_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_cmd && (cmd_i == CMD_RD || cmd_i == CMD_WR) && !bank_active_o[ba_i]) |=> err_no_row_o);

  assert_pre_pd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_mode_o == PWR_RUN && !cke_i && idle_cmd && bank_active_o == '0) |=> (pwr_mode_o == PWR_PRE_PD));

  assert_long_in_pd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pd_long_o |-> (pwr_mode_o != PWR_RUN));
endmodule

bind sdram_bank_tracker sdram_trk_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .ROW_W(ROW_W), .BA_W(BA_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .cmd_i(cmd_i), .ba_i(ba_i),
  .addr_i(addr_i), .bank_active_o(bank_active_o), .open_row_o(open_row_o),
  .pwr_mode_o(pwr_mode_o), .err_no_row_o(err_no_row_o), .err_trp_o(err_trp_o),
  .err_reopen_o(err_reopen_o), .err_pd_long_o(err_pd_long_o)
);

// File: tb/sdram_bank_tracker_tb_top.sv
`timescale 1ns/1ps
module sdram_bank_tracker_tb_top;
  localparam int T_RP = 3;
  localparam int LIM  = 20;
  localparam int RW   = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke = 1'b1;
  logic [2:0]    cmd = 3'd0;
  logic [0:0]    ba = 1'b0;
  logic [11:0]   addr = '0;
  logic [1:0]    act;
  logic [2*RW-1:0] rows;
  logic [1:0]    mode;
  logic          e_norow, e_trp, e_reopen, e_long;

  int total = 0;
  int bad   = 0;

  // reference state
  bit          m_act [2];
  logic [11:0] m_row [2];
  int          m_trp [2];
  int          m_mode, m_pd;
  bit          x_norow, x_trp, x_reopen;

  always #10 clk = ~clk;

  sdram_bank_tracker #(.T_RP(T_RP), .PD_LIMIT(LIM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cmd_i(cmd), .ba_i(ba), .addr_i(addr),
    .bank_active_o(act), .open_row_o(rows), .pwr_mode_o(mode),
    .err_no_row_o(e_norow), .err_trp_o(e_trp), .err_reopen_o(e_reopen),
    .err_pd_long_o(e_long)
  );

  task automatic chk(input bit ok, input string tag, input int actual, input int expect_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expect_v);
    end
  endtask

  function automatic bit is_idle_cmd(input logic [2:0] c);
    return (c == 3'd0) || (c == 3'd1);
  endfunction

  task automatic model(input bit k, input logic [2:0] c, input int b, input logic [11:0] a);
    int old_trp [2];
    x_norow = 0; x_trp = 0; x_reopen = 0;
    for (int i = 0; i < 2; i++) begin
      old_trp[i] = m_trp[i];
      if (m_trp[i] > 0) m_trp[i]--;
    end
    if (m_mode == 0) begin
      if (k) begin
        case (c)
          3'd2: if (m_act[b]) x_reopen = 1;
                else if (old_trp[b] != 0) x_trp = 1;
                else begin m_act[b] = 1; m_row[b] = a; end
          3'd3, 3'd4: if (!m_act[b]) x_norow = 1;
          3'd5: for (int i = 0; i < 2; i++)
                  if (a[10] || i == b) begin m_act[i] = 0; m_trp[i] = T_RP - 1; end
          default: ;
        endcase
      end else if (is_idle_cmd(c)) begin
        m_mode = (m_act[0] || m_act[1]) ? 2 : 1;
        m_pd = 0;
      end
    end else if (k && is_idle_cmd(c)) begin
      m_mode = 0; m_pd = 0;
    end else if (m_pd < LIM) begin
      m_pd++;
    end
  endtask

  task automatic step(input bit k, input logic [2:0] c, input int b, input logic [11:0] a,
                      input string tag);
    cke = k; cmd = c; ba = b[0]; addr = a;
    model(k, c, b, a);
    @(negedge clk);
    chk(act == {m_act[1], m_act[0]}, {tag, " R2 bank_active"}, act, {m_act[1], m_act[0]});
    chk(rows == {m_row[1], m_row[0]}, {tag, " R2 open_row"}, rows, {m_row[1], m_row[0]});
    chk(mode == m_mode[1:0], {tag, " R8 pwr_mode"}, mode, m_mode);
    chk(e_norow == x_norow, {tag, " R5 err_no_row"}, e_norow, x_norow);
    chk(e_trp == x_trp, {tag, " R6 err_trp"}, e_trp, x_trp);
    chk(e_reopen == x_reopen, {tag, " R7 err_reopen"}, e_reopen, x_reopen);
    chk(e_long == (m_mode != 0 && m_pd == LIM), {tag, " R10 err_pd_long"}, e_long,
        (m_mode != 0 && m_pd == LIM));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5d1a));
    for (int i = 0; i < 2; i++) begin m_act[i] = 0; m_row[i] = '0; m_trp[i] = 0; end
    m_mode = 0; m_pd = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(act == 2'b00 && rows == '0 && mode == 2'd0, "R1 reset state", {act, mode}, 0);
    chk({e_norow, e_trp, e_reopen, e_long} == 4'b0, "R1 reset errors",
        {e_norow, e_trp, e_reopen, e_long}, 0);
    rst_n = 1'b1;

    step(1, 3'd2, 0, 12'h123, "R2 open b0");
    step(1, 3'd2, 1, 12'h2ab, "R2 open b1");
    step(1, 3'd3, 0, 12'h000, "R5 read open");
    step(1, 3'd2, 0, 12'h456, "R7 reopen");
    step(1, 3'd5, 0, 12'h000, "R3 pre single");
    chk(act == 2'b10, "R3 only bank0 closed", act, 2'b10);
    step(1, 3'd2, 0, 12'h777, "R6 early act");
    step(1, 3'd0, 0, 12'h000, "R6 wait");
    step(1, 3'd2, 0, 12'h777, "R6 act at tRP");
    step(1, 3'd5, 1, 12'h400, "R4 pre all");
    chk(act == 2'b00, "R4 all closed", act, 0);
    step(1, 3'd4, 1, 12'h000, "R5 write idle");
    step(0, 3'd3, 0, 12'h000, "R11 cke low read");
    step(0, 3'd1, 0, 12'h000, "R8 enter ppd");
    chk(mode == 2'd1, "R8 precharge pd", mode, 1);
    for (int i = 0; i < LIM + 4; i++) step(0, 3'd0, 0, 12'h000, "R10 hold pd");
    chk(e_long == 1'b1, "R10 long flag", e_long, 1);
    step(1, 3'd2, 1, 12'h0aa, "R9 act in pd ignored");
    chk(act == 2'b00, "R9 state frozen", act, 0);
    step(1, 3'd0, 0, 12'h000, "R9 exit");
    step(1, 3'd2, 1, 12'h0bb, "R2 open b1");
    step(0, 3'd0, 0, 12'h000, "R8 enter apd");
    chk(mode == 2'd2, "R8 active pd", mode, 2);
    step(0, 3'd5, 0, 12'h400, "R9 pre in pd ignored");
    step(1, 3'd1, 0, 12'h000, "R9 exit inhibit");

    for (int n = 0; n < 3000; n++) begin
      bit k;
      k = ($urandom % 8) != 0;
      step(k, 3'($urandom % 8), int'($urandom % 2), 12'($urandom), "RND");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule